// File: doc/BRIEF.md
# One-Bit Accumulator Execution Core

This block is the execute stage of a serial, bit-wide processor. Each instruction holds an opcode in its top four bits. The core applies that opcode to a single operand bit taken from the data bus. It holds three one-bit registers: an accumulator, a carry and an output-enable. It produces a write-data bit and a write strobe for data memory. It also raises indications for NOP, jump and return, and it can squash the instruction that follows.

Every instruction takes two clock cycles, called phases. The core generates the phase itself, and it is low after reset. In the first phase the instruction is evaluated. In the second phase the memory write strobe is issued, and at the end of that phase the registers commit. The program counter, the operand address logic and the memories are outside the core. The surrounding logic holds the instruction and the operand bit stable across both phases. It uses the jump, return and squash outputs to steer its program counter.

Top module: `obc_core`

## Requirements
- R1: The opcode is taken from instruction bits 15:12, and bits 11:0 have no effect on the core. Opcode values: 0 NOP, 1 LD, 2 LDC, 3 STO, 4 STOC, 5 OEN, 6 ADD, 7 XNOR, 8 XOR, 9 AND, A OR, B ONE, C TWO, D JMP, E SKZ, F RET.
- R2: LD loads the operand into the accumulator and LDC loads its complement. XNOR, XOR, AND and OR combine the accumulator with the operand and leave the result in the accumulator.
- R3: ADD forms accumulator + carry + operand. The low bit of the sum goes to the accumulator and the carry-out goes to the carry register.
- R4: ONE sets the accumulator to 1 and the carry to 0. TWO sets the accumulator to 0 and the carry to 1.
- R5: The OEN opcode copies the operand bit into the output-enable register.
- R6: STO drives the accumulator on wr_data_o and STOC drives its complement. Either one pulses wr_en_o in phase 2 only, and only when output-enable is 1. With output-enable at 0, no store asserts wr_en_o.
- R7: When SKZ sees an operand of 0, the next instruction is squashed. An operand of 1 squashes nothing. SKZ leaves the accumulator and carry unchanged.
- R8: RET asserts ret_o in both phases and always squashes the next instruction.
- R9: JMP asserts jmp_o in both phases. NOP asserts nop_o in phase 2 only.
- R10: While squash_o is high, the current instruction changes no register and asserts none of wr_en_o, nop_o, jmp_o or ret_o. Squash then clears, so a squashed SKZ or RET never squashes the instruction after it.
- R11: Reset clears the accumulator, carry, output-enable, squash and phase.
- R12: phase_o alternates on every clock. Registers change only on the clock edge that ends phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Current instruction, held stable for both phases |
| bus_i | input | 1 | Operand bit read from the data bus |
| phase_o | output | 1 | 0 = evaluate phase, 1 = commit phase |
| wr_data_o | output | 1 | Bit to be written to data memory |
| wr_en_o | output | 1 | Data memory write strobe (phase 2) |
| nop_o | output | 1 | NOP indication (phase 2) |
| jmp_o | output | 1 | Jump indication (both phases) |
| ret_o | output | 1 | Return indication (both phases) |
| squash_o | output | 1 | Current instruction is being skipped |
| acc_o | output | 1 | Accumulator |
| carry_o | output | 1 | Carry register |
| oen_o | output | 1 | Output-enable register |

## Verification
The bench builds the core with its default geometry: a 16-bit instruction whose opcode field starts at bit 12. With this geometry, all sixteen opcodes can be reached with every operand value. The twelve bits below the opcode are filled with random values, so any leak of those bits into the behaviour becomes visible. Long random runs reach chains of skips, such as SKZ followed by RET. They also reach stores issued while output-enable is both high and low, and every carry combination of ADD.

// File: rtl/obc_pkg.sv
package obc_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0, OP_LD   = 4'h1, OP_LDC  = 4'h2, OP_STO  = 4'h3,
    OP_STOC = 4'h4, OP_OEN  = 4'h5, OP_ADD  = 4'h6, OP_XNOR = 4'h7,
    OP_XOR  = 4'h8, OP_AND  = 4'h9, OP_OR   = 4'hA, OP_ONE  = 4'hB,
    OP_TWO  = 4'hC, OP_JMP  = 4'hD, OP_SKZ  = 4'hE, OP_RET  = 4'hF
  } opcode_e;

  typedef struct packed {
    logic wr_acc;
    logic wr_carry;
    logic ld_oen;
    logic store;
    logic invert_st;
    logic nop;
    logic jmp;
    logic ret;
    logic skz;
  } dec_t;

  typedef struct packed {
    logic acc;
    logic carry;
  } alu_res_t;

  // full adder: returns {carry_out, sum}
  function automatic logic [1:0] add3(input logic a, input logic b, input logic c);
    add3 = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

  function automatic alu_res_t alu_eval(input opcode_e op, input logic acc,
                                        input logic carry, input logic opnd);
    alu_res_t r;
    logic [1:0] s;
    r = '{acc: acc, carry: carry};
    s = add3(acc, opnd, carry);
    unique case (op)
      OP_LD:   r.acc = opnd;
      OP_LDC:  r.acc = ~opnd;
      OP_ADD:  begin r.acc = s[0]; r.carry = s[1]; end
      OP_XNOR: r.acc = ~(acc ^ opnd);
      OP_XOR:  r.acc = acc ^ opnd;
      OP_AND:  r.acc = acc & opnd;
      OP_OR:   r.acc = acc | opnd;
      OP_ONE:  begin r.acc = 1'b1; r.carry = 1'b0; end
      OP_TWO:  begin r.acc = 1'b0; r.carry = 1'b1; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/obc_decode.sv
module obc_decode
  import obc_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output opcode_e          op_o,
  output dec_t             dec_o
);
  always_comb begin
    op_o  = opcode_e'(opc_i);
    dec_o = '0;
    unique case (op_o)
      OP_NOP:  dec_o.nop = 1'b1;
      OP_STO:  dec_o.store = 1'b1;
      OP_STOC: begin dec_o.store = 1'b1; dec_o.invert_st = 1'b1; end
      OP_OEN:  dec_o.ld_oen = 1'b1;
      OP_ADD, OP_ONE, OP_TWO: begin dec_o.wr_acc = 1'b1; dec_o.wr_carry = 1'b1; end
      OP_LD, OP_LDC, OP_XNOR, OP_XOR, OP_AND, OP_OR: dec_o.wr_acc = 1'b1;
      OP_JMP:  dec_o.jmp = 1'b1;
      OP_SKZ:  dec_o.skz = 1'b1;
      OP_RET:  dec_o.ret = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/obc_alu.sv
module obc_alu
  import obc_pkg::*;
(
  input  opcode_e op_i,
  input  logic    acc_i,
  input  logic    carry_i,
  input  logic    opnd_i,
  output logic    acc_nx_o,
  output logic    carry_nx_o
);
  alu_res_t res;
  always_comb begin
    res        = alu_eval(op_i, acc_i, carry_i, opnd_i);
    acc_nx_o   = res.acc;
    carry_nx_o = res.carry;
  end
endmodule

// File: rtl/obc_seq.sv
module obc_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic skip_set_i,
  output logic phase_o,
  output logic squash_o
);
  logic phase_q, squash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      squash_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) squash_q <= skip_set_i & ~squash_q;
    end
  end

  assign phase_o  = phase_q;
  assign squash_o = squash_q;
endmodule

// File: rtl/obc_core.sv
module obc_core
  import obc_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int OP_LSB  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               bus_i,
  output logic               phase_o,
  output logic               wr_data_o,
  output logic               wr_en_o,
  output logic               nop_o,
  output logic               jmp_o,
  output logic               ret_o,
  output logic               squash_o,
  output logic               acc_o,
  output logic               carry_o,
  output logic               oen_o
);
  localparam int OP_MSB = OP_LSB + OPC_W - 1;

  opcode_e op;
  dec_t    dec;
  logic    acc_q, carry_q, oen_q;
  logic    acc_nx, carry_nx;
  logic    live, commit_ev, skip_set_ev;

  obc_decode u_dec (
    .opc_i (instr_i[OP_MSB:OP_LSB]),
    .op_o  (op),
    .dec_o (dec)
  );

  obc_alu u_alu (
    .op_i       (op),
    .acc_i      (acc_q),
    .carry_i    (carry_q),
    .opnd_i     (bus_i),
    .acc_nx_o   (acc_nx),
    .carry_nx_o (carry_nx)
  );

  // named events for the checker
  assign live        = ~squash_o;
  assign commit_ev   = phase_o & live;
  assign skip_set_ev = dec.ret | (dec.skz & ~bus_i);

  obc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .skip_set_i (skip_set_ev),
    .phase_o    (phase_o),
    .squash_o   (squash_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      carry_q <= 1'b0;
      oen_q   <= 1'b0;
    end else if (commit_ev) begin
      if (dec.wr_acc)   acc_q   <= acc_nx;
      if (dec.wr_carry) carry_q <= carry_nx;
      if (dec.ld_oen)   oen_q   <= bus_i;
    end
  end

  assign wr_data_o = acc_q ^ dec.invert_st;
  assign wr_en_o   = commit_ev & dec.store & oen_q;
  assign nop_o     = commit_ev & dec.nop;
  assign jmp_o     = live & dec.jmp;
  assign ret_o     = live & dec.ret;
  assign acc_o     = acc_q;
  assign carry_o   = carry_q;
  assign oen_o     = oen_q;
endmodule

// File: rtl/obc_core_chk.sv
module obc_core_chk #(
  parameter int INSTR_W = 16,
  parameter int OP_LSB  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [INSTR_W-1:0] instr_i,
  input logic               bus_i,
  input logic               phase_o,
  input logic               wr_en_o,
  input logic               nop_o,
  input logic               jmp_o,
  input logic               ret_o,
  input logic               squash_o,
  input logic               acc_o,
  input logic               carry_o,
  input logic               oen_o
);
  logic [3:0] opc;
  assign opc = instr_i[OP_LSB +: 4];

  p_phase_alt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o |=> !phase_o);
  p_hold_p1_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o |=> $stable({acc_o, carry_o, oen_o}));
  p_wr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (oen_o && phase_o));
  p_nop_p2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nop_o |-> phase_o);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> !(wr_en_o || nop_o || jmp_o || ret_o));
  p_squash_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_o && phase_o) |=> !squash_o);
  p_squash_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> $stable({acc_o, carry_o, oen_o}));
  p_ret_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_o && phase_o) |=> squash_o);
  p_skz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o && !squash_o && opc == 4'hE && !bus_i) |=> (squash_o && $stable(acc_o)));
  p_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o && !squash_o && opc == 4'hB) |=> (acc_o && !carry_o));
endmodule

bind obc_core obc_core_chk #(.INSTR_W(INSTR_W), .OP_LSB(OP_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .bus_i(bus_i),
  .phase_o(phase_o), .wr_en_o(wr_en_o), .nop_o(nop_o), .jmp_o(jmp_o),
  .ret_o(ret_o), .squash_o(squash_o), .acc_o(acc_o), .carry_o(carry_o),
  .oen_o(oen_o)
);

// File: tb/obc_core_bench.sv
`timescale 1ns/1ps
module obc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        bus = 1'b0;
  logic phase, wr_data, wr_en, nop, jmp, ret, squash, acc, carry, oen;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic m_acc, m_carry, m_oen, m_skip;

  always #2.5 clk = ~clk;

  obc_core u_obc_core (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .bus_i(bus),
    .phase_o(phase), .wr_data_o(wr_data), .wr_en_o(wr_en), .nop_o(nop),
    .jmp_o(jmp), .ret_o(ret), .squash_o(squash), .acc_o(acc),
    .carry_o(carry), .oen_o(oen)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] ref_add(input logic a, input logic b, input logic c);
    int s;
    s = int'(a) + int'(b) + int'(c);
    return s[1:0];
  endfunction

  task automatic model_step(input logic [3:0] op, input logic b);
    logic [1:0] s;
    if (m_skip) begin
      m_skip = 1'b0;
      return;
    end
    case (op)
      4'h1: m_acc = b;
      4'h2: m_acc = !b;
      4'h5: m_oen = b;
      4'h6: begin s = ref_add(m_acc, m_carry, b); m_acc = s[0]; m_carry = s[1]; end
      4'h7: m_acc = (m_acc == b);
      4'h8: m_acc = (m_acc != b);
      4'h9: m_acc = m_acc && b;
      4'hA: m_acc = m_acc || b;
      4'hB: begin m_acc = 1'b1; m_carry = 1'b0; end
      4'hC: begin m_acc = 1'b0; m_carry = 1'b1; end
      default: ;
    endcase
    m_skip = (op == 4'hF) || (op == 4'hE && b == 1'b0);
  endtask

  // called at a negedge while phase is 0; returns at the negedge after commit
  task automatic run_op(input logic [3:0] op, input logic b);
    logic live, st;
    chk("R12 acc", acc, m_acc);
    chk("R3 carry", carry, m_carry);
    chk("R5 oen", oen, m_oen);
    chk("R10 squash", squash, m_skip);
    live = !m_skip;
    st   = live && m_oen && (op == 4'h3 || op == 4'h4);
    instr = {op, 12'($urandom)};   // R1 low bits random
    bus   = b;
    #1;
    chk("R12 phase1", phase, 1'b0);
    chk("R9 jmp p1", jmp, live && op == 4'hD);
    chk("R8 ret p1", ret, live && op == 4'hF);
    chk("R9 nop p1", nop, 1'b0);
    chk("R6 wr_en p1", wr_en, 1'b0);
    @(negedge clk); #1;
    chk("R12 phase2", phase, 1'b1);
    chk("R9 jmp p2", jmp, live && op == 4'hD);
    chk("R8 ret p2", ret, live && op == 4'hF);
    chk("R9 nop p2", nop, live && op == 4'h0);
    chk("R6 wr_en p2", wr_en, st);
    if (st) chk("R6 wr_data", wr_data, (op == 4'h4) ? !m_acc : m_acc);
    model_step(op, b);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b17));
    m_acc = 0; m_carry = 0; m_oen = 0; m_skip = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 acc", acc, 1'b0);
    chk("R11 carry", carry, 1'b0);
    chk("R11 oen", oen, 1'b0);
    chk("R11 squash", squash, 1'b0);
    chk("R11 phase", phase, 1'b0);
    @(negedge clk); @(negedge clk);   // realign to a phase-1 negedge

    // R6 stores with output-enable low: no strobe
    run_op(4'hB, 0); run_op(4'h3, 1); run_op(4'h4, 0);
    // R5 enable, then R6 stores
    run_op(4'h5, 1); run_op(4'h3, 0); run_op(4'h4, 0);
    // R4 and R3 carry chains
    run_op(4'hC, 0); run_op(4'h6, 1); run_op(4'h6, 1); run_op(4'h6, 0);
    // R2 logic ops
    run_op(4'h1, 1); run_op(4'h7, 0); run_op(4'h8, 1); run_op(4'h9, 1);
    run_op(4'hA, 1); run_op(4'h2, 1);
    // R7 SKZ taken then ADD squashed; SKZ not taken
    run_op(4'hB, 0); run_op(4'hE, 0); run_op(4'h6, 1); run_op(4'hE, 1); run_op(4'h1, 0);
    // R8 RET squashes JMP; R10 squashed SKZ/RET do not chain
    run_op(4'hF, 1); run_op(4'hD, 1); run_op(4'hE, 0); run_op(4'hE, 0);
    run_op(4'h0, 0); run_op(4'hF, 0); run_op(4'hF, 0); run_op(4'h0, 1);
    // R9 plain NOP and JMP
    run_op(4'h0, 1); run_op(4'hD, 0);

    // random mix covering R1..R10
    for (int i = 0; i < 600; i++) begin
      run_op(4'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule